// File: doc/BRIEF.md
# Convergent Rounding Stage

This stage sits at the output of a full-precision filter and shortens its wide signed result to a narrow signed word, 16 bits by default. A fixed number of low bits, set by a parameter, is treated as a binary fraction and removed. The remaining value is rounded to the nearest integer. When the fraction is exactly one half, the tie goes to whichever neighbour is even. Both plain truncation and round-half-away-from-zero add a DC offset to a long stream of samples. The even-tie rule has no such offset, because ties go up and down equally often.

If rounding carries the value past the output range, the result is clamped to the range limit instead of wrapping. A one-bit valid travels with the data, and the result appears one clock after the sample is accepted. When no sample is offered, the output word keeps its last value.

Top module: `conv_round_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid sample, `o_valid` is 0 and `o_data` is 0.
- R2: When the discarded fraction (the low `DROP_W` bits of `i_data`) is not exactly one half, `o_data` is the integer nearest to `i_data / 2^DROP_W`. A fraction of zero passes the kept bits through unchanged.
- R3: For a non-negative input whose fraction is exactly one half (top discarded bit 1 and all lower discarded bits 0), the result is the even neighbour: 1.5 gives 2, 2.5 gives 2, 0.5 gives 0.
- R4: Negative inputs use the same tie rule in two's complement: -1.5 gives -2, -2.5 gives -2, -0.5 gives 0.
- R5: A result above the largest output value (32767 for the 16-bit default) is clamped to that value, and a result below the smallest value is clamped to the smallest. With the default widths, 32767.5 gives 32767.
- R6: `o_valid` equals `i_valid` from the previous rising clock edge, and the matching `o_data` appears on that same edge.
- R7: When `i_valid` is 0 at a rising edge, `o_data` keeps its previous value across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Input sample qualifier |
| i_data | input | IN_W (24) | Signed full-precision value; the low DROP_W (8) bits are the fraction |
| o_valid | output | 1 | Output sample qualifier |
| o_data | output | OUT_W (16) | Rounded and saturated signed result |

## Verification
Every result appears one rising edge after its sample is accepted: `o_data` and `o_valid` both change on the edge that captures `i_data`. The bench applies each input at a falling edge and checks the output at the next falling edge, half a period after the capturing edge. It applies the next input at that same falling edge, so back-to-back samples stream without gaps. The hold behaviour is checked one falling edge after a cycle with `i_valid` low, before any further valid sample. The reset values are checked while reset is held and again right after it is released.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

  // Classification of the discarded fraction relative to one half
  typedef enum logic [1:0] {
    FRAC_BELOW = 2'd0,
    FRAC_HALF  = 2'd1,
    FRAC_ABOVE = 2'd2
  } frac_cls_e;

endpackage

// File: rtl/cvr_frac_class.sv
module cvr_frac_class
  import cvr_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic [DROP_W-1:0] frac,
  output frac_cls_e         cls
);

  generate
    if (DROP_W == 1) begin : g_single
      always_comb begin
        cls = frac[0] ? FRAC_HALF : FRAC_BELOW;
      end
    end else begin : g_multi
      logic rest_zero;
      always_comb begin
        rest_zero = (frac[DROP_W-2:0] == '0);
        if (!frac[DROP_W-1])   cls = FRAC_BELOW;
        else if (rest_zero)    cls = FRAC_HALF;
        else                   cls = FRAC_ABOVE;
      end
    end
  endgenerate

endmodule

// File: rtl/cvr_round_add.sv
module cvr_round_add
  import cvr_pkg::*;
#(
  parameter int KEEP_W = 16,
  localparam int SUM_W = KEEP_W + 1
) (
  input  logic [KEEP_W-1:0] kept,
  input  frac_cls_e         cls,
  output logic [SUM_W-1:0]  sum
);

  logic bump;

  // Ties go up only when the kept LSB is odd, giving an even result
  always_comb begin
    bump = (cls == FRAC_ABOVE) || ((cls == FRAC_HALF) && kept[0]);
    sum  = {kept[KEEP_W-1], kept} + {{(SUM_W-1){1'b0}}, bump};
  end

endmodule

// File: rtl/cvr_saturate.sv
module cvr_saturate #(
  parameter int SUM_W = 17,
  parameter int OUT_W = 16
) (
  input  logic [SUM_W-1:0] sum,
  output logic [OUT_W-1:0] res
);

  localparam logic [OUT_W-1:0] LIM_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] LIM_LO = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (SUM_W > OUT_W) begin : g_clamp
      localparam int TOP_W = SUM_W - OUT_W + 1;
      logic [TOP_W-1:0] top_bits;
      logic             fits;
      always_comb begin
        top_bits = sum[SUM_W-1:OUT_W-1];
        fits     = (top_bits == '0) || (top_bits == '1);
        if (fits)                res = sum[OUT_W-1:0];
        else if (sum[SUM_W-1])   res = LIM_LO;
        else                     res = LIM_HI;
      end
    end else begin : g_extend
      always_comb begin
        res = {{(OUT_W-SUM_W){sum[SUM_W-1]}}, sum};
      end
    end
  endgenerate

endmodule

// File: rtl/conv_round_unit.sv
module conv_round_unit
  import cvr_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int DROP_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [IN_W-1:0]   i_data,
  output logic              o_valid,
  output logic [OUT_W-1:0]  o_data
);

  localparam int KEEP_W = IN_W - DROP_W;
  localparam int SUM_W  = KEEP_W + 1;

  frac_cls_e        cls;
  logic [SUM_W-1:0] sum;
  logic [OUT_W-1:0] res;

  cvr_frac_class #(.DROP_W(DROP_W)) u_cls (
    .frac (i_data[DROP_W-1:0]),
    .cls  (cls)
  );

  cvr_round_add #(.KEEP_W(KEEP_W)) u_add (
    .kept (i_data[IN_W-1:DROP_W]),
    .cls  (cls),
    .sum  (sum)
  );

  cvr_saturate #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_sat (
    .sum (sum),
    .res (res)
  );

  // Output stage: next-state and register processes kept apart
  logic             vld_q, vld_d;
  logic [OUT_W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = i_valid;
    dat_d = dat_q;
    if (i_valid) dat_d = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign o_valid = vld_q;
  assign o_data  = dat_q;

  // ---------------- assertions ----------------
  localparam int CW = ((IN_W > OUT_W + DROP_W) ? IN_W : OUT_W + DROP_W) + 2;
  localparam logic signed [CW-1:0] HALF_X = $signed(CW'(1) << (DROP_W - 1));
  localparam logic [OUT_W-1:0] OUT_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic [IN_W-1:0]        chk_in;
  logic signed [CW-1:0]   chk_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_in <= '0;
    else if (i_valid) chk_in <= i_data;
  end

  always_comb begin
    chk_err = CW'($signed(chk_in)) - (CW'($signed(o_data)) <<< DROP_W);
  end

  // R6: valid follows the input qualifier by one edge
  assert_valid_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> o_valid);
  assert_invalid_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> !o_valid);

  // R7: output word holds when nothing is offered
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> $stable(o_data));

  // R2: an unclamped result lies within half an output step of the input
  assert_near_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_data != OUT_HI && o_data != OUT_LO) |->
      (chk_err <= HALF_X && chk_err >= -HALF_X));

  // R3: an exact midpoint that is not clamped leaves an even result
  assert_tie_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && chk_in[DROP_W-1:0] == HALF_X[DROP_W-1:0] && o_data != OUT_HI)
      |-> !o_data[0]);

endmodule

// File: tb/tb_conv_round_unit.sv
`timescale 1ns/1ps
module tb_conv_round_unit;

  localparam int IN_W = 24, DROP_W = 8, OUT_W = 16;
  localparam int NV = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             i_valid;
  logic [IN_W-1:0]  i_data;
  logic             o_valid;
  logic [OUT_W-1:0] o_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  conv_round_unit #(.IN_W(IN_W), .DROP_W(DROP_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_data(i_data),
    .o_valid(o_valid), .o_data(o_data)
  );

  // {input, expected, requirement number}
  // R2 nearest, R3 positive ties, R4 negative ties, R5 clamp
  localparam logic [47:0] VEC [NV] = '{
    {24'h000180, 16'h0002, 8'd3},  //  1.5 -> 2
    {24'h000280, 16'h0002, 8'd3},  //  2.5 -> 2
    {24'h000080, 16'h0000, 8'd3},  //  0.5 -> 0
    {24'h000380, 16'h0004, 8'd3},  //  3.5 -> 4
    {24'hFFFE80, 16'hFFFE, 8'd4},  // -1.5 -> -2
    {24'hFFFD80, 16'hFFFE, 8'd4},  // -2.5 -> -2
    {24'hFFFF80, 16'h0000, 8'd4},  // -0.5 -> 0
    {24'h800180, 16'h8002, 8'd4},  // -32766.5 -> -32766
    {24'h800080, 16'h8000, 8'd4},  // -32767.5 -> -32768
    {24'h000140, 16'h0001, 8'd2},  //  1.25 -> 1
    {24'h0001C0, 16'h0002, 8'd2},  //  1.75 -> 2
    {24'hFFFEC0, 16'hFFFF, 8'd2},  // -1.25 -> -1
    {24'hFFFE40, 16'hFFFE, 8'd2},  // -1.75 -> -2
    {24'h000500, 16'h0005, 8'd2},  //  5.0 -> 5
    {24'h000181, 16'h0002, 8'd2},  //  just above 1.5 -> 2
    {24'h00027F, 16'h0002, 8'd2},  //  just below 2.5 -> 2
    {24'h800000, 16'h8000, 8'd2},  //  most negative passes
    {24'h7FFE80, 16'h7FFE, 8'd5},  //  32766.5 -> 32766
    {24'h7FFF80, 16'h7FFF, 8'd5},  //  32767.5 clamps to 32767
    {24'h7FFFFF, 16'h7FFF, 8'd5}   //  near 32768 clamps
  };

  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] x);
    longint v, q, r;
    v = longint'($signed(x));
    q = v >>> DROP_W;
    r = v - q * 256;
    if (r > 128 || (r == 128 && q[0])) q = q + 1;
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q[OUT_W-1:0];
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic push(input logic [IN_W-1:0] x, input logic [OUT_W-1:0] exp,
                      input string req);
    i_data  = x;
    i_valid = 1'b1;
    @(negedge clk);
    check("R6 valid", {15'd0, o_valid}, 16'd1);
    check(req, o_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; i_data = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {15'd0, o_valid}, 16'd0);
    check("R1 data in reset", o_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {15'd0, o_valid}, 16'd0);
    check("R1 data after release", o_data, 16'd0);

    // vector table walk
    for (int k = 0; k < NV; k++) begin
      push(VEC[k][47:24], VEC[k][23:8], $sformatf("R%0d vec %0d", VEC[k][7:0], k));
    end

    // R7: idle cycle with new data on the bus keeps the last word
    i_valid = 1'b0;
    i_data  = 24'h001234;
    @(negedge clk);
    check("R6 idle valid", {15'd0, o_valid}, 16'd0);
    check("R7 hold", o_data, 16'h7FFF);
    @(negedge clk);
    check("R7 hold second", o_data, 16'h7FFF);

    // every midpoint: R3 and R4
    for (int k = -32768; k < 32768; k++) begin
      logic [IN_W-1:0] x;
      x = {k[15:0], 8'h80};
      push(x, model(x), (k < 0) ? "R4 tie sweep" : "R3 tie sweep");
    end

    // random sweep against the model: R2 and R5
    for (int k = 0; k < 4000; k++) begin
      logic [IN_W-1:0] x;
      x = IN_W'($urandom);
      push(x, model(x), "R2 random");
    end

    // R1: reset mid-stream clears the outputs
    rst_n = 1'b0;
    #1;
    check("R1 async clear data", o_data, 16'd0);
    check("R1 async clear valid", {15'd0, o_valid}, 16'd0);
    i_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule